// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

After a write instruction to a serial EEPROM has been closed with STOP, the memory spends some time copying its latched data into the array and does not answer on the bus. This block, on the master side, waits out that period by probing the device instead of sitting through the worst-case write time. Each probe is a START condition followed by the device select byte. When the memory does not acknowledge, it is still busy: the block closes the bus with STOP, leaves it idle for a minimum number of cycles and probes again. When the memory acknowledges, its internal write has finished. The block then stops and leaves the bus addressed. The acknowledged probe serves as the first byte of whatever instruction the requester sends next, so that byte is not sent again.

The block drives a byte-level I2C engine through a small command port (START, send byte, STOP) and reads back one response per command, which carries the acknowledge bit for a sent byte. A requester starts a poll with a one-cycle request that carries the three chip-select bits and the R/W bit. The R/W bit is supplied so that either a read or a write can follow. A cycle counter limits the total wait and ends an unanswered poll with a timeout.

Top module: `ack_poller`

## Requirements
- R1: After synchronous reset, `poll_busy`, `poll_done`, `poll_ready`, `poll_timeout` and `cmd_valid` are all low.
- R2: Each probe attempt is a START command (`cmd_op` = 0) followed, once its response arrives, by a SEND command (`cmd_op` = 1) whose `cmd_byte` is {4'b1010, chip[2:0], rw}, with chip and rw captured when the request was accepted.
- R3: A response to a SEND with `rsp_nack` = 1 is followed in the next cycle by a STOP command (`cmd_op` = 2); after the STOP response (when not timed out) a new START is issued.
- R4: Between the response to a STOP and the next START command, `cmd_valid` stays low for at least `GAP_CYC` cycles.
- R5: A response to a SEND with `rsp_nack` = 0 ends the poll in the next cycle with `poll_done` high and `poll_ready` = 1; no STOP and no further SEND is issued for that poll.
- R6: If at the end of a STOP response at least `TIMEOUT_CYC` cycles have passed since the request was accepted, the poll ends with `poll_done` high, `poll_timeout` = 1 and `poll_ready` = 0; a timeout never ends a poll earlier than `TIMEOUT_CYC` cycles after the request.
- R7: `poll_busy` rises in the cycle after an accepted request and stays high until the cycle in which the one-cycle `poll_done` pulse appears, where it is low; `cmd_valid` is only high while busy.
- R8: A request while busy is ignored: the chip and R/W bits in use do not change and no second completion follows.
- R9: `poll_ready` and `poll_timeout` hold their value after completion and are both cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| poll_req | input | 1 | One-cycle request to start polling |
| poll_chip | input | 3 | Chip-select bits placed in the device select byte |
| poll_rw | input | 1 | R/W bit placed in the device select byte |
| poll_busy | output | 1 | High while a poll is running |
| poll_done | output | 1 | One-cycle completion pulse |
| poll_ready | output | 1 | Last poll ended with an acknowledge |
| poll_timeout | output | 1 | Last poll ended without an acknowledge in time |
| cmd_valid | output | 1 | One-cycle command to the byte engine |
| cmd_op | output | 2 | Command: 0 START, 1 SEND, 2 STOP |
| cmd_byte | output | 8 | Byte to send with a SEND command |
| rsp_valid | input | 1 | Byte engine finished the last command |
| rsp_nack | input | 1 | Acknowledge bit of a SEND (1 = not acknowledged) |

## Verification
The bench builds the poller with `GAP_CYC` = 3 and `TIMEOUT_CYC` = 60. The short limit lets a device that never answers reach the timeout after about four probe attempts. The short gap makes the idle-bus spacing measurable on every retry. The bench stands in for the byte engine with a two-cycle response latency and acknowledges after a chosen number of refused probes. This covers a first-try acknowledge, several retries, a timeout followed by a successful poll, and a request issued in the middle of a poll.

// File: rtl/ack_poller_pkg.sv
package ack_poller_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_STOP  = 2'd2
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_ISSUE,
        ST_START_WAIT,
        ST_SEL_ISSUE,
        ST_SEL_WAIT,
        ST_STOP_ISSUE,
        ST_STOP_WAIT,
        ST_GAP
    } poll_state_e;

    typedef struct packed {
        logic [2:0] chip;
        logic       rw;
    } poll_target_t;

    localparam logic [3:0] DEVICE_TYPE = 4'b1010;

    function automatic logic [7:0] select_byte(input poll_target_t t);
        return {DEVICE_TYPE, t.chip, t.rw};
    endfunction

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic en,
    output logic reached
);
    localparam int W = $clog2(LIMIT + 2);

    logic [W-1:0] cnt;

    assign reached = (cnt >= W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (en && !reached) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
    import ack_poller_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    rsp_valid,
    input  logic    rsp_nack,
    input  logic    gap_done,
    input  logic    wait_expired,
    output logic    accept,
    output logic    gap_clear,
    output logic    busy,
    output logic    cmd_valid,
    output bus_op_e cmd_op,
    output logic    done,
    output logic    ack_ok,
    output logic    timed_out
);
    poll_state_e state, state_n;
    logic finish_ok, finish_to;

    assign busy   = (state != ST_IDLE);
    assign accept = (state == ST_IDLE) && req;

    always_comb begin
        state_n   = state;
        finish_ok = 1'b0;
        finish_to = 1'b0;
        gap_clear = 1'b0;
        unique case (state)
            ST_IDLE:        if (req) state_n = ST_START_ISSUE;
            ST_START_ISSUE: state_n = ST_START_WAIT;
            ST_START_WAIT:  if (rsp_valid) state_n = ST_SEL_ISSUE;
            ST_SEL_ISSUE:   state_n = ST_SEL_WAIT;
            ST_SEL_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_nack) begin
                        state_n = ST_STOP_ISSUE;
                    end else begin
                        state_n   = ST_IDLE;
                        finish_ok = 1'b1;
                    end
                end
            end
            ST_STOP_ISSUE:  state_n = ST_STOP_WAIT;
            ST_STOP_WAIT: begin
                if (rsp_valid) begin
                    if (wait_expired) begin
                        state_n   = ST_IDLE;
                        finish_to = 1'b1;
                    end else begin
                        state_n   = ST_GAP;
                        gap_clear = 1'b1;
                    end
                end
            end
            ST_GAP:         if (gap_done) state_n = ST_START_ISSUE;
            default:        state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_START;
        case (state)
            ST_START_ISSUE: cmd_valid = 1'b1;
            ST_SEL_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_SEND;
            end
            ST_STOP_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            done      <= 1'b0;
            ack_ok    <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            state <= state_n;
            done  <= finish_ok || finish_to;
            if (accept) begin
                ack_ok    <= 1'b0;
                timed_out <= 1'b0;
            end else begin
                if (finish_ok) ack_ok    <= 1'b1;
                if (finish_to) timed_out <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ack_poller.sv
module ack_poller
    import ack_poller_pkg::*;
#(
    parameter int GAP_CYC     = 8,
    parameter int TIMEOUT_CYC = 2500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       poll_req,
    input  logic [2:0] poll_chip,
    input  logic       poll_rw,
    output logic       poll_busy,
    output logic       poll_done,
    output logic       poll_ready,
    output logic       poll_timeout,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic [7:0] cmd_byte,
    input  logic       rsp_valid,
    input  logic       rsp_nack
);
    poll_target_t target;
    bus_op_e      op;
    logic         accept, gap_clear, gap_done, wait_expired, busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            target <= '0;
        end else if (accept) begin
            target <= '{chip: poll_chip, rw: poll_rw};
        end
    end

    sat_counter #(.LIMIT(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .clear   (gap_clear),
        .en      (1'b1),
        .reached (gap_done)
    );

    sat_counter #(.LIMIT(TIMEOUT_CYC)) u_elapsed (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .en      (busy),
        .reached (wait_expired)
    );

    poll_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req          (poll_req),
        .rsp_valid    (rsp_valid),
        .rsp_nack     (rsp_nack),
        .gap_done     (gap_done),
        .wait_expired (wait_expired),
        .accept       (accept),
        .gap_clear    (gap_clear),
        .busy         (busy),
        .cmd_valid    (cmd_valid),
        .cmd_op       (op),
        .done         (poll_done),
        .ack_ok       (poll_ready),
        .timed_out    (poll_timeout)
    );

    assign poll_busy = busy;
    assign cmd_op    = op;
    assign cmd_byte  = select_byte(target);
endmodule

// File: rtl/ack_poller_checker.sv
module ack_poller_checker #(
    parameter int GAP_CYC = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       poll_req,
    input logic       poll_busy,
    input logic       poll_done,
    input logic       poll_ready,
    input logic       poll_timeout,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [3:0] sel_type,
    input logic       rsp_valid,
    input logic       rsp_nack
);
    logic [1:0]  last_op;
    logic        after_stop;
    logic [15:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_op    <= 2'd0;
            after_stop <= 1'b0;
            idle_cnt   <= '0;
        end else begin
            if (cmd_valid) last_op <= cmd_op;
            if (rsp_valid && last_op == 2'd2) begin
                after_stop <= 1'b1;
                idle_cnt   <= '0;
            end else if (cmd_valid) begin
                after_stop <= 1'b0;
            end else if (after_stop && idle_cnt != 16'hFFFF) begin
                idle_cnt <= idle_cnt + 16'd1;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> !poll_busy && !poll_done && !cmd_valid);

    assert_select_type_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 2'd1 |-> sel_type == 4'b1010);

    assert_nack_stop_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_nack && last_op == 2'd1 && poll_busy
        |=> cmd_valid && cmd_op == 2'd2);

    assert_bus_gap_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 2'd0 && after_stop |-> idle_cnt >= 16'(GAP_CYC));

    assert_ack_finish_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_nack && last_op == 2'd1 && poll_busy
        |=> poll_done && poll_ready && !cmd_valid);

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
        poll_done |-> $onehot({poll_ready, poll_timeout}));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        poll_done |=> !poll_done);

    assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
        poll_req && !poll_busy |=> poll_busy);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        poll_done |-> !poll_busy);

    assert_cmd_busy_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> poll_busy);
endmodule

bind ack_poller ack_poller_checker #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .poll_req     (poll_req),
    .poll_busy    (poll_busy),
    .poll_done    (poll_done),
    .poll_ready   (poll_ready),
    .poll_timeout (poll_timeout),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .sel_type     (cmd_byte[7:4]),
    .rsp_valid    (rsp_valid),
    .rsp_nack     (rsp_nack)
);

// File: tb/ack_poller_test.sv
module ack_poller_test;
    localparam int GAP = 3;
    localparam int TO  = 60;
    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       poll_req = 1'b0;
    logic [2:0] poll_chip = 3'd0;
    logic       poll_rw = 1'b0;
    logic       poll_busy, poll_done, poll_ready, poll_timeout;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [7:0] cmd_byte;
    logic       rsp_valid = 1'b0;
    logic       rsp_nack = 1'b0;

    ack_poller #(.GAP_CYC(GAP), .TIMEOUT_CYC(TO)) uut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // byte-engine model state
    int ops_q[$];
    int bytes_q[$];
    int pend = 0;
    int cur_op = 0;
    int probes = 0;
    int nack_limit = 0;
    bit after_stop = 0;
    int idle = 0;

    // cycle model state
    bit pend_req = 0;
    bit exp_busy = 0;
    bit prev_done = 0;
    int done_cnt = 0;
    int done_cyc = 0;
    int req_cyc = 0;
    bit got_ready = 0;
    bit got_timeout = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // byte engine: accepts on cmd_valid, answers LAT cycles later
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        rsp_nack  = 1'b0;
        if (cmd_valid) begin
            if (after_stop && cmd_op == 2'd0)
                check(idle >= GAP, "R4", "idle cycles before new START", idle, GAP);
            after_stop = 0;
            ops_q.push_back(int'(cmd_op));
            if (cmd_op == 2'd1) bytes_q.push_back(int'(cmd_byte));
            cur_op = int'(cmd_op);
            pend = LAT;
        end else begin
            if (after_stop) idle++;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid = 1'b1;
                    if (cur_op == 1) begin
                        rsp_nack = (probes < nack_limit);
                        probes++;
                    end
                    if (cur_op == 2) begin
                        after_stop = 1;
                        idle = 0;
                    end
                end
            end
        end
    end

    // per-cycle model comparison, sampled 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (!rst) begin
            if (pend_req) begin
                exp_busy = 1;
                pend_req = 0;
                req_cyc  = cyc;
            end
            if (poll_done) begin
                check(!prev_done, "R7", "done pulse longer than one cycle", 1, 0);
                check(poll_busy == 1'b0, "R7", "busy at done", poll_busy, 0);
                done_cnt++;
                done_cyc    = cyc;
                got_ready   = poll_ready;
                got_timeout = poll_timeout;
                exp_busy    = 0;
            end else if (poll_busy != exp_busy) begin
                check(0, "R7", "busy vs model", poll_busy, exp_busy);
            end
            if (cmd_valid && !poll_busy) check(0, "R7", "cmd_valid while idle", 1, 0);
            prev_done = poll_done;
        end
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_poll(input int nacks, input logic [2:0] chip, input logic rw,
                            input bit inject);
        ops_q.delete();
        bytes_q.delete();
        probes = 0;
        nack_limit = nacks;
        done_cnt = 0;
        @(negedge clk);
        poll_chip = chip;
        poll_rw   = rw;
        poll_req  = 1'b1;
        pend_req  = 1;
        @(negedge clk);
        poll_req  = 1'b0;
        if (inject) begin
            repeat (10) @(negedge clk);
            poll_chip = ~chip;
            poll_rw   = ~rw;
            poll_req  = 1'b1;
            @(negedge clk);
            poll_req  = 1'b0;
        end
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic check_ack_run(input int nacks, input int exp_byte, input string tag);
        int exp_ops[$];
        for (int a = 0; a < nacks; a++) begin
            exp_ops.push_back(0);
            exp_ops.push_back(1);
            exp_ops.push_back(2);
        end
        exp_ops.push_back(0);
        exp_ops.push_back(1);
        check(done_cnt == 1, tag, "completions", done_cnt, 1);
        check(got_ready == 1'b1, "R5", "ready flag", got_ready, 1);
        check(got_timeout == 1'b0, "R9", "timeout flag", got_timeout, 0);
        check(ops_q.size() == exp_ops.size(), "R3", "command count", ops_q.size(), exp_ops.size());
        for (int k = 0; k < ops_q.size() && k < exp_ops.size(); k++)
            if (ops_q[k] != exp_ops[k]) check(0, "R2", "command order", ops_q[k], exp_ops[k]);
        check(bytes_q.size() == nacks + 1, "R5", "select bytes sent", bytes_q.size(), nacks + 1);
        foreach (bytes_q[k])
            check(bytes_q[k] == exp_byte, tag, "select byte", bytes_q[k], exp_byte);
        check(poll_ready == 1'b1, "R9", "ready held after done", poll_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(poll_busy == 0, "R1", "busy after reset", poll_busy, 0);
        check(poll_done == 0, "R1", "done after reset", poll_done, 0);
        check(cmd_valid == 0, "R1", "cmd_valid after reset", cmd_valid, 0);
        check(poll_ready == 0 && poll_timeout == 0, "R1", "flags after reset",
              {poll_ready, poll_timeout}, 0);

        // R5: acknowledge on the first probe, chip 2 rw 0 -> 0xA4
        run_poll(0, 3'd2, 1'b0, 0);
        check_ack_run(0, 8'hA4, "R2");

        // R3: two refusals, chip 5 rw 1 -> 0xAB
        run_poll(2, 3'd5, 1'b1, 0);
        check_ack_run(2, 8'hAB, "R2");

        // R6: device never answers, chip 7 rw 0 -> 0xAE
        run_poll(1000, 3'd7, 1'b0, 0);
        check(done_cnt == 1, "R6", "timeout completions", done_cnt, 1);
        check(got_timeout == 1'b1, "R6", "timeout flag", got_timeout, 1);
        check(got_ready == 1'b0, "R6", "ready flag on timeout", got_ready, 0);
        check(done_cyc - req_cyc >= TO, "R6", "cycles before timeout", done_cyc - req_cyc, TO);
        check(ops_q.size() > 0 && ops_q[ops_q.size()-1] == 2, "R6", "last command is STOP",
              ops_q.size() > 0 ? ops_q[ops_q.size()-1] : -1, 2);
        check(bytes_q.size() >= 2, "R3", "probe attempts before timeout", bytes_q.size(), 2);
        foreach (bytes_q[k])
            check(bytes_q[k] == 8'hAE, "R2", "select byte during timeout", bytes_q[k], 8'hAE);
        check(poll_timeout == 1'b1, "R9", "timeout held after done", poll_timeout, 1);

        // R9: after a timeout, a successful poll clears the timeout flag; chip 0 rw 1 -> 0xA1
        run_poll(1, 3'd0, 1'b1, 0);
        check_ack_run(1, 8'hA1, "R9");

        // R8: request in the middle of a poll is ignored; chip 1 rw 0 -> 0xA2
        run_poll(2, 3'd1, 1'b0, 1);
        check_ack_run(2, 8'hA2, "R8");
        check(poll_busy == 1'b0, "R8", "no restart after ignored request", poll_busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule